// File: doc/BRIEF.md
# Memory Request Coalescer

This block takes one memory request from a group of sixteen threads and turns it into the smallest set of aligned memory transactions. The request gives an active bit for each thread, a byte address for each thread, and one access size shared by all threads. Each thread's address is treated as naturally aligned to the access size. The block works in rounds. In each round it picks the lowest-numbered thread that is still pending. It finds the aligned segment that holds that thread's address, sized by the access width. Every other pending thread whose address falls in the same segment joins the round.

Before the transaction is issued, the segment is halved once or twice if all the bytes the joining threads touch fit in one half. Each transaction leaves on a valid/ready stream as a base address, a byte count and a thread mask. The threads it covers then retire. A one-cycle done pulse marks the end of the request. A request with no active threads finishes at once and issues no transaction.

Top module: `mem_coalescer`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1, and `txn_valid` and `done` are 0.
- R2: The starting segment size is set by `req_size`: code 0 (1-byte access) gives 32 bytes, code 1 (2-byte) gives 64, and code 2 (4-byte) and code 3 (8-byte) both give 128. `txn_base` is always a multiple of `txn_bytes`.
- R3: Each transaction is anchored on the lowest-numbered thread still pending, and that thread's bit is set in `txn_mask`.
- R4: `txn_mask` holds exactly the pending threads whose address falls in the anchor thread's segment.
- R5: If every byte the joining threads touch lies in one 64-byte half of a 128-byte segment, the transaction shrinks to that 64-byte half. Then, if every touched byte lies in one 32-byte half of the 64-byte span, it shrinks again to 32 bytes. `txn_base` moves to the chosen half.
- R6: A thread served by a transaction is never served again. Across one request, the OR of all transaction masks equals the request's active mask, and no transaction is issued after the last thread is served.
- R7: While `txn_valid` is 1 and `txn_ready` is 0, the transaction outputs hold their values. The next round starts only after the current transaction is accepted.
- R8: `done` is 1 for the single cycle after the last transaction is accepted. `txn_valid` is 0 while `done` is 1.
- R9: A request with an all-zero active mask issues no transaction and raises `done` in the cycle after it is accepted.
- R10: `req_ready` is 0 while a request is being processed. Request inputs presented during that time have no effect on the transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_active | input | 16 | Per-thread active bits |
| req_addr | input | 512 | Per-thread byte addresses, thread t at bits [32t+31:32t] |
| req_size | input | 2 | Access size code: 0=1 B, 1=2 B, 2=4 B, 3=8 B |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Transaction consumer ready |
| txn_base | output | 32 | Transaction base byte address |
| txn_bytes | output | 8 | Transaction size in bytes (32, 64 or 128) |
| txn_mask | output | 16 | Threads served by this transaction |
| done | output | 1 | One-cycle pulse at the end of a request |

## Verification
Every access size is swept against six address layouts:
- Unit stride must fold into one transaction.
- Double stride shows where segment boundaries split a group.
- A permuted layout with a sparse mask checks that the anchor is the lowest pending thread, not the lowest address.
- A broadcast of one address checks that all threads join and the segment shrinks to 32 bytes.
- A layout confined to one upper quarter of a segment separates the two shrinking steps and checks the shifted base.
- A fully scattered layout forces one transaction per thread.

Stalls on the output handshake, junk requests presented while busy, and an empty request cover the hold, the ignored-input and the immediate-done behaviour.

// File: rtl/coal_pkg.sv
package coal_pkg;

  typedef enum logic [1:0] {
    ACC_B1 = 2'd0,
    ACC_B2 = 2'd1,
    ACC_B4 = 2'd2,
    ACC_B8 = 2'd3
  } acc_size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } coal_state_e;

  // log2 of the starting segment size for an access size code
  function automatic logic [2:0] seg_shift_f(input logic [1:0] code);
    case (code)
      ACC_B1:  seg_shift_f = 3'd5;
      ACC_B2:  seg_shift_f = 3'd6;
      default: seg_shift_f = 3'd7;
    endcase
  endfunction

  // log2 of the per-thread access width
  function automatic logic [2:0] acc_shift_f(input logic [1:0] code);
    acc_shift_f = {1'b0, code};
  endfunction

endpackage

// File: rtl/coal_seg_match.sv
module coal_seg_match #(
  parameter int NT = 16,
  parameter int AW = 32
) (
  input  logic [NT-1:0]    pending,
  input  logic [NT*AW-1:0] addr_flat,
  input  logic [1:0]       size_code,
  output logic [NT-1:0]    hit,
  output logic [AW-1:0]    seg_base,
  output logic [2:0]       seg_shift,
  output logic [6:0]       lo_off,
  output logic [6:0]       hi_off
);
  import coal_pkg::*;

  localparam int IW = (NT > 1) ? $clog2(NT) : 1;

  logic [IW-1:0] lead_idx;
  logic [AW-1:0] lead_addr;
  logic [AW-1:0] seg_mask;
  logic [2:0]    acc_shift;
  logic [6:0]    acc_span;
  logic [6:0]    off [NT];

  assign seg_shift = seg_shift_f(size_code);
  assign acc_shift = acc_shift_f(size_code);
  assign seg_mask  = {AW{1'b1}} << seg_shift;
  assign acc_span  = ~({7{1'b1}} << acc_shift);

  // anchor: lowest-numbered pending thread
  always_comb begin
    lead_idx = '0;
    for (int t = NT - 1; t >= 0; t--) begin
      if (pending[t]) lead_idx = IW'(t);
    end
  end

  assign lead_addr = addr_flat[lead_idx*AW +: AW];
  assign seg_base  = lead_addr & seg_mask;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    assign hit[t] = pending[t] &&
                    ((addr_flat[t*AW +: AW] & seg_mask) == seg_base);
    assign off[t] = addr_flat[t*AW +: 7] & ~seg_mask[6:0] & ~acc_span;
  end

  // touched byte range of the joining threads, relative to the segment
  always_comb begin
    lo_off = 7'h7f;
    hi_off = 7'h00;
    for (int t = 0; t < NT; t++) begin
      if (hit[t]) begin
        if (off[t] < lo_off) lo_off = off[t];
        if ((off[t] | acc_span) > hi_off) hi_off = off[t] | acc_span;
      end
    end
  end

endmodule

// File: rtl/coal_shrink.sv
module coal_shrink #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] seg_base,
  input  logic [2:0]    seg_shift,
  input  logic [6:0]    lo_off,
  input  logic [6:0]    hi_off,
  output logic [AW-1:0] out_base,
  output logic [7:0]    out_bytes
);

  always_comb begin
    out_bytes = 8'd1 << seg_shift;
    out_base  = seg_base;
    if (out_bytes == 8'd128 && lo_off[6] == hi_off[6]) begin
      out_bytes   = 8'd64;
      out_base[6] = lo_off[6];
    end
    if (out_bytes == 8'd64 && lo_off[5] == hi_off[5]) begin
      out_bytes   = 8'd32;
      out_base[5] = lo_off[5];
    end
  end

endmodule

// File: rtl/mem_coalescer.sv
module mem_coalescer #(
  parameter int NT = 16,
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [NT-1:0]    req_active,
  input  logic [NT*AW-1:0] req_addr,
  input  logic [1:0]       req_size,
  output logic             txn_valid,
  input  logic             txn_ready,
  output logic [AW-1:0]    txn_base,
  output logic [7:0]       txn_bytes,
  output logic [NT-1:0]    txn_mask,
  output logic             done
);
  import coal_pkg::*;

  coal_state_e      state_q, state_d;
  logic [NT-1:0]    pend_q, pend_d;
  logic [NT*AW-1:0] addr_q;
  logic [1:0]       size_q;
  logic             done_q, done_d;
  logic             accept;
  logic             issue;

  logic [NT-1:0]    hit;
  logic [AW-1:0]    seg_base;
  logic [2:0]       seg_shift;
  logic [6:0]       lo_off, hi_off;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign txn_valid = (state_q == ST_BUSY);
  assign issue     = txn_valid && txn_ready;
  assign txn_mask  = hit;
  assign done      = done_q;

  coal_seg_match #(.NT(NT), .AW(AW)) u_match (
    .pending   (pend_q),
    .addr_flat (addr_q),
    .size_code (size_q),
    .hit       (hit),
    .seg_base  (seg_base),
    .seg_shift (seg_shift),
    .lo_off    (lo_off),
    .hi_off    (hi_off)
  );

  coal_shrink #(.AW(AW)) u_shrink (
    .seg_base  (seg_base),
    .seg_shift (seg_shift),
    .lo_off    (lo_off),
    .hi_off    (hi_off),
    .out_base  (txn_base),
    .out_bytes (txn_bytes)
  );

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          pend_d = req_active;
          if (req_active == '0) done_d = 1'b1;
          else                  state_d = ST_BUSY;
        end
      end
      default: begin
        if (issue) begin
          pend_d = pend_q & ~hit;
          if (pend_d == '0) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
    end
  end

  // request datapath capture, enable only
  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q <= req_addr;
      size_q <= req_size;
    end
  end

endmodule

// File: rtl/mem_coalescer_chk.sv
module mem_coalescer_chk #(
  parameter int NT = 16,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          txn_valid,
  input logic          txn_ready,
  input logic [AW-1:0] txn_base,
  input logic [7:0]    txn_bytes,
  input logic [NT-1:0] txn_mask,
  input logic          done
);

  p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_base & (AW'(txn_bytes) - AW'(1))) == '0));

  p_size_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_bytes == 8'd32 || txn_bytes == 8'd64 || txn_bytes == 8'd128));

  p_mask_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_mask != '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=>
      (txn_valid && $stable(txn_base) && $stable(txn_bytes) && $stable(txn_mask)));

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !txn_valid);

  p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(txn_valid && txn_ready) || $past(req_valid && req_ready)));

  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !req_ready);

endmodule

bind mem_coalescer mem_coalescer_chk #(.NT(NT), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .txn_valid (txn_valid),
  .txn_ready (txn_ready),
  .txn_base  (txn_base),
  .txn_bytes (txn_bytes),
  .txn_mask  (txn_mask),
  .done      (done)
);

// File: tb/mem_coalescer_tb_top.sv
module mem_coalescer_tb_top;
  localparam int NT = 16;
  localparam int AW = 32;

  logic             clk;
  logic             rst_n;
  logic             req_valid;
  logic             req_ready;
  logic [NT-1:0]    req_active;
  logic [NT*AW-1:0] req_addr;
  logic [1:0]       req_size;
  logic             txn_valid;
  logic             txn_ready;
  logic [AW-1:0]    txn_base;
  logic [7:0]       txn_bytes;
  logic [NT-1:0]    txn_mask;
  logic             done;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  logic [31:0] a_addr [NT];
  logic [31:0] e_base [NT];
  logic [31:0] e_bytes[NT];
  logic [15:0] e_mask [NT];
  int          e_n;

  mem_coalescer #(.NT(NT), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_active(req_active), .req_addr(req_addr), .req_size(req_size),
    .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_base(txn_base), .txn_bytes(txn_bytes), .txn_mask(txn_mask),
    .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference: rounds built from the requirements
  task automatic model(input logic [15:0] act, input logic [1:0] sz);
    logic [15:0] pend;
    int sb, ab, lead, lo, hi, off;
    logic [31:0] base;
    pend = act;
    e_n  = 0;
    ab   = 1 << sz;
    sb   = (sz == 0) ? 32 : (sz == 1) ? 64 : 128;
    while (pend != 0) begin
      lead = 0;
      for (int t = NT - 1; t >= 0; t--) if (pend[t]) lead = t;
      base = a_addr[lead] - (a_addr[lead] % sb);
      e_mask[e_n] = '0;
      lo = 1000; hi = -1;
      for (int t = 0; t < NT; t++) begin
        if (pend[t] && (a_addr[t] - (a_addr[t] % sb)) == base) begin
          e_mask[e_n][t] = 1'b1;
          off = (a_addr[t] - (a_addr[t] % ab)) - base;
          if (off < lo) lo = off;
          if (off + ab - 1 > hi) hi = off + ab - 1;
        end
      end
      e_bytes[e_n] = sb;
      if (sb == 128 && lo / 64 == hi / 64) begin
        e_bytes[e_n] = 64;
        base = base + (lo / 64) * 64;
        lo = lo % 64; hi = hi % 64;
      end
      if (e_bytes[e_n] == 64 && lo / 32 == hi / 32) begin
        e_bytes[e_n] = 32;
        base = base + (lo / 32) * 32;
      end
      e_base[e_n] = base;
      pend = pend & ~e_mask[e_n];
      e_n++;
    end
  endtask

  task automatic run(input logic [15:0] act, input logic [1:0] sz, input bit junk_in);
    int k, guard;
    bit rdy, junk;
    logic [15:0] seen;
    model(act, sz);
    junk = junk_in && (e_n > 0);
    @(negedge clk);
    req_valid  = 1'b1;
    req_active = act;
    req_size   = sz;
    for (int t = 0; t < NT; t++) req_addr[t*AW +: AW] = a_addr[t];
    @(negedge clk);
    req_valid = junk;
    if (junk) begin
      req_active = '1;
      req_size   = ~sz;
      req_addr   = {NT{32'h0BAD_0040}};
    end
    if (e_n == 0) begin
      chk(done == 1'b1 && txn_valid == 1'b0, "R9 empty request done", {31'd0, done}, 32'd1);
      @(negedge clk);
      chk(done == 1'b0, "R9 done pulse ends", {31'd0, done}, 32'd0);
      return;
    end
    k = 0; guard = 0; seen = '0;
    while (k < e_n && guard < 300) begin
      guard++;
      if (!txn_valid) begin
        chk(1'b0, "R6 transaction missing", 32'd0, 32'd1);
        break;
      end
      chk(req_ready == 1'b0, "R10 ready low while busy", {31'd0, req_ready}, 32'd0);
      chk(txn_bytes == e_bytes[k][7:0], "R2_R5 txn bytes", {24'd0, txn_bytes}, e_bytes[k]);
      chk(txn_base == e_base[k], "R2_R5 txn base", txn_base, e_base[k]);
      chk(txn_mask == e_mask[k], "R3_R4 txn mask", {16'd0, txn_mask}, {16'd0, e_mask[k]});
      rdy = (cyc % 3) != 1;
      cyc++;
      txn_ready = rdy;
      if (rdy) seen = seen | txn_mask;
      @(negedge clk);
      if (rdy) begin
        k++;
        if (k == e_n) begin
          req_valid = 1'b0;
          chk(done == 1'b1 && txn_valid == 1'b0, "R8 done after last accept",
              {31'd0, done}, 32'd1);
        end else begin
          chk(done == 1'b0, "R8 no early done", {31'd0, done}, 32'd0);
        end
      end
    end
    txn_ready = 1'b0;
    req_valid = 1'b0;
    chk(seen == act, "R6 all active threads served once", {16'd0, seen}, {16'd0, act});
    @(negedge clk);
    chk(done == 1'b0 && txn_valid == 1'b0, "R8 done is one cycle, no extra txn",
        {30'd0, done, txn_valid}, 32'd0);
  endtask

  task automatic build(input int sz, input int pat, input int seed, output logic [15:0] act);
    int ab;
    logic [31:0] b0;
    ab = 1 << sz;
    b0 = 32'h0001_0000 + seed * 2048;
    act = 16'hFFFF;
    for (int t = 0; t < NT; t++) begin
      case (pat)
        0: a_addr[t] = b0 + t * ab;
        1: a_addr[t] = b0 + t * 2 * ab;
        2: a_addr[t] = b0 + ((t * 7) % 16) * ab;
        3: a_addr[t] = b0 + 40;
        4: a_addr[t] = b0 + 96 + (t % 4) * ab;
        default: a_addr[t] = b0 + t * 128 + (t % 2) * 32;
      endcase
      a_addr[t] = a_addr[t] - (a_addr[t] % ab);
    end
    if (pat == 2) act = 16'hA5C3;
    if (pat == 4) act = 16'h0F0E;
  endtask

  initial begin
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_active = '0;
    req_addr   = '0;
    req_size   = '0;
    txn_ready  = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && txn_valid == 1'b0 && done == 1'b0, "R1 reset state",
        {29'd0, req_ready, txn_valid, done}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && txn_valid == 1'b0 && done == 1'b0, "R1 after reset",
        {29'd0, req_ready, txn_valid, done}, 32'd4);
    for (int sz = 0; sz < 4; sz++) begin
      for (int pat = 0; pat < 6; pat++) begin
        logic [15:0] act;
        build(sz, pat, sz * 6 + pat, act);
        run(act, 2'(sz), (pat % 2) == 1);
      end
    end
    build(2, 0, 30, req_active);
    run(16'h0000, 2'd2, 1'b1);
    build(3, 5, 31, req_active);
    run(16'h8001, 2'd3, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule